// File: doc/BRIEF.md
# Quad-Rate Burst-Four SRAM Front End

This block models the control logic on the device side of a quad-data-rate static memory with independent read and write ports. Every transfer moves four words. The true and complementary input clock edges are represented by one fast clock, running at twice the main rate, and by an internal phase flag. A cycle with the flag low stands for a rising edge of the main clock. A cycle with the flag high stands for a rising edge of its complement.

Commands and addresses are sampled only on main-clock edges. Write data and active-low byte enables are sampled on every fast cycle of a write burst and go straight into a register-file array that is split into byte lanes. A read burst returns its four words on consecutive fast cycles after a fixed latency, with a valid flag. Each port ignores its own strobe while its burst is still running, and a write yields to a read that starts on the same edge. A pair of free-running echo outputs mirrors the phase, so a receiver can use it as a data strobe.

Top module: `qdr_burst_sram`

## Requirements
- R1: `k_phase` is 0 during reset and in the first cycle after reset is released, and then toggles every cycle. `echo_p` equals `k_phase` and `echo_n` is its complement in every cycle, whether or not a burst is active.
- R2: `rd_n` and `wr_n` are acted on only in cycles where `k_phase` is 0. A strobe that is low only in a cycle with `k_phase` 1 starts nothing.
- R3: A write accepted in cycle t0 captures word k (k = 0..3) from `wdata` in cycle t0+k and stores it at word address {addr, k}, where the two offset bits are the least significant. Byte lane b (bits b*BYTE_W upward) is stored only if `bwe_n[b]` is 0 in that same cycle.
- R4: A read accepted in cycle t0 places word k of burst `addr` on `rdata` in cycle t0+2*READ_LAT+k. `rvalid` is high in exactly those four cycles, so word 0 always falls in a cycle with `k_phase` 0.
- R5: While `rvalid` is 0, including during reset, `rdata` is all zeros.
- R6: A read strobe is ignored in the main-clock cycle that directly follows an accepted read. It can be accepted again two main-clock cycles after the accepted one.
- R7: A write strobe is ignored in the main-clock cycle that directly follows an accepted write. It can be accepted again two main-clock cycles after the accepted one.
- R8: A write strobe in a cycle where a read is accepted is ignored. A write strobe alongside a read strobe that is itself being ignored under R6 is accepted.
- R9: When neither command is accepted, `addr`, `wdata` and `bwe_n` change neither the array nor the read outputs.
- R10: A word driven on `rdata` in cycle T reflects every write captured in cycle T-2 or earlier. This includes writes to the same burst that overlap the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, two cycles per main-clock period |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Burst address |
| wdata | input | DATA_W | Write data word |
| bwe_n | input | DATA_W/BYTE_W | Active-low byte-lane write enables |
| rdata | output | DATA_W | Read data word |
| rvalid | output | 1 | High while a read word is on `rdata` |
| k_phase | output | 1 | 0 in cycles that stand for main-clock edges |
| echo_p | output | 1 | Free-running echo, equal to the phase |
| echo_n | output | 1 | Complement of `echo_p` |

## Verification
The checker assumes that `rd_n` and `wr_n` are known and high while reset is asserted. It also assumes that the parameters give whole byte lanes and a read latency of at least one main-clock cycle. The bench holds both strobes high through reset and then changes its inputs only at falling edges, starting each scenario on a main-clock cycle so that phase alignment is controlled. Write data and enables change on every cycle, even when no command is active. This exercises the ignore rules without breaking what the assertions assume.

// File: rtl/qbs_pkg.sv
package qbs_pkg;
   localparam int BEATS  = 4;
   localparam int BEAT_W = $clog2(BEATS);
   typedef logic [BEAT_W-1:0] beat_t;
endpackage

// File: rtl/qbs_burst_seq.sv
// Burst position counter: goes to 1 after a start, counts to 3, then idles at 0.
module qbs_burst_seq
   import qbs_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  go,
   output beat_t cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (go)
         cnt <= beat_t'(1);
      else if (cnt != '0)
         cnt <= cnt + beat_t'(1);
   end
endmodule

// File: rtl/qbs_start_delay.sv
// Carries read starts and their burst addresses through a fixed number of cycles.
module qbs_start_delay #(
   parameter int DEPTH = 3,
   parameter int AW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_v,
   input  logic [AW-1:0] in_a,
   output logic          out_v,
   output logic [AW-1:0] out_a
);
   logic [DEPTH-1:0] v_sr;
   logic [AW-1:0]    a_sr [DEPTH];

   generate
      if (DEPTH == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) v_sr[0] <= 1'b0;
            else        v_sr[0] <= in_v;
         end
         always_ff @(posedge clk) a_sr[0] <= in_a;
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (!rst_n) v_sr <= '0;
            else        v_sr <= {v_sr[DEPTH-2:0], in_v};
         end
         always_ff @(posedge clk) begin
            a_sr[0] <= in_a;
            for (int i = 1; i < DEPTH; i++)
               a_sr[i] <= a_sr[i-1];
         end
      end
   endgenerate

   assign out_v = v_sr[DEPTH-1];
   assign out_a = a_sr[DEPTH-1];
endmodule

// File: rtl/qbs_lane_bank.sv
// One byte lane of the array: write port, plus a registered read that returns zero when idle.
module qbs_lane_bank #(
   parameter int WORD_AW = 8,
   parameter int LANE_W  = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [WORD_AW-1:0] waddr,
   input  logic [LANE_W-1:0]  wdata,
   input  logic               re,
   input  logic [WORD_AW-1:0] raddr,
   output logic [LANE_W-1:0]  rdata
);
   localparam int WORDS = 1 << WORD_AW;

   logic [LANE_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= mem[raddr];
      else         rdata <= '0;
   end
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram
   import qbs_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 18,
   parameter int BYTE_W   = 9,
   parameter int READ_LAT = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rd_n,
   input  logic                       wr_n,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          wdata,
   input  logic [DATA_W/BYTE_W-1:0]   bwe_n,
   output logic [DATA_W-1:0]          rdata,
   output logic                       rvalid,
   output logic                       k_phase,
   output logic                       echo_p,
   output logic                       echo_n
);
   localparam int LANES   = DATA_W / BYTE_W;
   localparam int WORD_AW = ADDR_W + BEAT_W;
   localparam int DLY     = 2 * READ_LAT - 1;

   initial begin : g_param_check
      assert (DATA_W % BYTE_W == 0) else $error("DATA_W must be a whole number of lanes");
      assert (READ_LAT >= 1)        else $error("READ_LAT must be at least 1");
      assert (ADDR_W >= 1)          else $error("ADDR_W must be at least 1");
   end

   // phase: 0 stands for a main-clock rising edge
   logic phase_q;
   always_ff @(posedge clk) begin
      if (!rst_n) phase_q <= 1'b0;
      else        phase_q <= ~phase_q;
   end
   assign k_phase = phase_q;
   assign echo_p  = phase_q;
   assign echo_n  = ~phase_q;

   // command acceptance, each port blanked by its own burst
   beat_t rd_cnt, wr_cnt;
   logic  rd_go, wr_go;
   assign rd_go = !phase_q && !rd_n && (rd_cnt == '0);
   assign wr_go = !phase_q && !wr_n && (wr_cnt == '0) && !rd_go;

   qbs_burst_seq u_rd_acc (.clk(clk), .rst_n(rst_n), .go(rd_go), .cnt(rd_cnt));
   qbs_burst_seq u_wr_seq (.clk(clk), .rst_n(rst_n), .go(wr_go), .cnt(wr_cnt));

   // write path: words go to the array in the cycle they are captured
   logic [ADDR_W-1:0]  wa_q;
   logic [ADDR_W-1:0]  wa_sel;
   logic               wr_act;
   beat_t              wr_beat;
   logic [WORD_AW-1:0] wword;

   always_ff @(posedge clk) begin
      if (!rst_n)     wa_q <= '0;
      else if (wr_go) wa_q <= addr;
   end
   assign wa_sel  = wr_go ? addr : wa_q;
   assign wr_act  = wr_go || (wr_cnt != '0);
   assign wr_beat = wr_go ? '0 : wr_cnt;
   assign wword   = {wa_sel, wr_beat};

   // read path: start delay, then a four-cycle fetch sequence
   logic              dl_v;
   logic [ADDR_W-1:0] dl_a;
   qbs_start_delay #(.DEPTH(DLY), .AW(ADDR_W)) u_dly (
      .clk(clk), .rst_n(rst_n), .in_v(rd_go), .in_a(addr),
      .out_v(dl_v), .out_a(dl_a)
   );

   beat_t              f_cnt;
   logic [ADDR_W-1:0]  fa_q;
   logic               f_act;
   beat_t              f_beat;
   logic [WORD_AW-1:0] rword;

   qbs_burst_seq u_fetch (.clk(clk), .rst_n(rst_n), .go(dl_v), .cnt(f_cnt));

   always_ff @(posedge clk) begin
      if (!rst_n)    fa_q <= '0;
      else if (dl_v) fa_q <= dl_a;
   end
   assign f_act  = dl_v || (f_cnt != '0);
   assign f_beat = dl_v ? '0 : f_cnt;
   assign rword  = {(dl_v ? dl_a : fa_q), f_beat};

   always_ff @(posedge clk) begin
      if (!rst_n) rvalid <= 1'b0;
      else        rvalid <= f_act;
   end

   // byte-lane array
   wire [DATA_W-1:0] rd_word;
   generate
      for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
         qbs_lane_bank #(.WORD_AW(WORD_AW), .LANE_W(BYTE_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_act && !bwe_n[ln]),
            .waddr (wword),
            .wdata (wdata[ln*BYTE_W +: BYTE_W]),
            .re    (f_act),
            .raddr (rword),
            .rdata (rd_word[ln*BYTE_W +: BYTE_W])
         );
      end
   endgenerate
   assign rdata = rd_word;
endmodule

// File: rtl/qbs_checker.sv
module qbs_checker #(
   parameter int DATA_W   = 18,
   parameter int READ_LAT = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              k_phase,
   input logic              echo_p,
   input logic              echo_n,
   input logic              rvalid,
   input logic [DATA_W-1:0] rdata,
   input logic              rd_go,
   input logic              wr_go
);
   localparam int SPAN = 2 * READ_LAT;

   logic [SPAN-1:0] go_sr;
   logic [1:0]      vcnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         go_sr <= '0;
         vcnt  <= '0;
      end else begin
         go_sr <= {go_sr[SPAN-2:0], rd_go};
         if (rvalid) vcnt <= vcnt + 2'd1;
      end
   end

   assert_echo_toggle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (echo_p != $past(echo_p)));

   assert_echo_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (echo_n == $past(echo_p)));

   assert_rd_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n, 2) && $past(rd_go, 2)) |-> !rd_go);

   assert_wr_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n, 2) && $past(wr_go, 2)) |-> !wr_go);

   assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      go_sr[SPAN-1] |-> (rvalid && !k_phase));

   assert_first_word_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rvalid) |-> !k_phase);

   assert_whole_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rvalid) |-> (vcnt == 2'd0));

   assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rvalid |-> (rdata == '0));
endmodule

bind qdr_burst_sram qbs_checker #(.DATA_W(DATA_W), .READ_LAT(READ_LAT)) u_chk (
   .clk(clk), .rst_n(rst_n), .k_phase(k_phase), .echo_p(echo_p), .echo_n(echo_n),
   .rvalid(rvalid), .rdata(rdata), .rd_go(rd_go), .wr_go(wr_go)
);

// File: tb/sim_qdr_burst_sram.sv
module sim_qdr_burst_sram;
   localparam int AW = 3;
   localparam int DW = 16;
   localparam int BW = 8;
   localparam int RL = 2;
   localparam int NL = DW / BW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_n = 1'b1;
   logic          wr_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [NL-1:0] bwe_n = '1;
   wire  [DW-1:0] rdata;
   wire           rvalid, k_phase, echo_p, echo_n;

   always #5 clk = ~clk;

   qdr_burst_sram #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(BW), .READ_LAT(RL)) u0 (
      .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
      .wdata(wdata), .bwe_n(bwe_n), .rdata(rdata), .rvalid(rvalid),
      .k_phase(k_phase), .echo_p(echo_p), .echo_n(echo_n)
   );

   int    nchk = 0;
   int    nerr = 0;
   int    wd   = 0;
   string cur_req = "R3";
   logic  be_mode = 1'b0;
   logic [15:0] sc = 16'd0;

   task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // reference model, derived from the requirements
   logic [DW-1:0] mem_m [4<<AW];
   logic          ph_m;
   logic [1:0]    rbz, wbz, off;
   logic [AW-1:0] wa_m, wa;
   int            mcyc, idx;
   logic          due_v [16];
   logic [AW-1:0] due_a [16];
   logic          exp_v;
   logic [DW-1:0] exp_d;
   logic          kedge, racc, wacc;

   initial for (int i = 0; i < (4<<AW); i++) mem_m[i] = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         ph_m = 1'b0; rbz = '0; wbz = '0; wa_m = '0; mcyc = 0;
         exp_v = 1'b0; exp_d = '0;
         for (int i = 0; i < 16; i++) due_v[i] = 1'b0;
      end else begin
         kedge = !ph_m;
         racc  = kedge && !rd_n && (rbz == 2'd0);
         wacc  = kedge && !wr_n && (wbz == 2'd0) && !racc;
         // word due next cycle sees memory before this cycle's write (R10)
         exp_v = 1'b0; exp_d = '0;
         for (int k = 0; k < 4; k++) begin
            idx = (mcyc + 1 - k) & 15;
            if (due_v[idx]) begin
               exp_v = 1'b1;
               exp_d = mem_m[{due_a[idx], 2'(k)}];
               if (k == 3) due_v[idx] = 1'b0;
            end
         end
         if (racc) begin
            due_v[(mcyc + 2*RL) & 15] = 1'b1;
            due_a[(mcyc + 2*RL) & 15] = addr;
         end
         if (wacc || wbz != 2'd0) begin
            off = wacc ? 2'd0 : wbz;
            wa  = wacc ? addr : wa_m;
            for (int b = 0; b < NL; b++)
               if (!bwe_n[b]) mem_m[{wa, off}][b*BW +: BW] = wdata[b*BW +: BW];
         end
         if (wacc) wa_m = addr;
         rbz  = racc ? 2'd1 : ((rbz != 2'd0) ? rbz + 2'd1 : 2'd0);
         wbz  = wacc ? 2'd1 : ((wbz != 2'd0) ? wbz + 2'd1 : 2'd0);
         ph_m = ~ph_m;
         mcyc++;
      end
   end

   always @(negedge clk) begin
      wd++;
      if (wd > 20000) begin
         nerr++;
         $display("FAIL R4 watchdog cycles=%0d expected below %0d", wd, 20000);
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
      if (rst_n) begin
         check(k_phase === ph_m && echo_p === ph_m && echo_n === ~ph_m, "R1",
               DW'({k_phase, echo_p, echo_n}), DW'({ph_m, ph_m, ~ph_m}));
         check(rvalid === exp_v, cur_req, DW'(rvalid), DW'(exp_v));
         check(rdata === exp_d, exp_v ? cur_req : "R5", rdata, exp_d);
      end
   end

   task automatic step(input logic r, input logic w, input logic [AW-1:0] a);
      rd_n  = r;
      wr_n  = w;
      addr  = a;
      wdata = (sc * 16'h03b1) ^ 16'h5a0f;
      bwe_n = be_mode ? sc[NL-1:0] : '0;
      sc++;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) step(1'b1, 1'b1, '0);
   endtask

   task automatic wr_burst(input logic [AW-1:0] a);
      step(1'b1, 1'b0, a);
      idle(3);
   endtask

   task automatic rd_burst(input logic [AW-1:0] a);
      step(1'b0, 1'b1, a);
      idle(3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // reset state (R1, R5)
      check(rvalid === 1'b0 && rdata === '0, "R5", rdata, '0);
      check(k_phase === 1'b0, "R1", DW'(k_phase), '0);
      rst_n = 1'b1;

      // R3: fill all bursts with full enables
      cur_req = "R3";
      for (int a = 0; a < (1<<AW); a++) wr_burst(AW'(a));
      // R4: read all bursts back to back
      cur_req = "R4";
      for (int a = 0; a < (1<<AW); a++) rd_burst(AW'(a));
      idle(8);

      // R3: byte-enable sweep over every lane combination
      cur_req = "R3";
      be_mode = 1'b1;
      for (int a = 0; a < (1<<AW); a++) wr_burst(AW'(a));
      be_mode = 1'b0;
      for (int a = 0; a < (1<<AW); a++) rd_burst(AW'(a));
      idle(8);

      // R6: read strobe held into the next main-clock edge
      cur_req = "R6";
      step(1'b0, 1'b1, 3'd2); idle(1);
      step(1'b0, 1'b1, 3'd5); idle(1);
      idle(8);

      // R7: write strobe held into the next main-clock edge
      cur_req = "R7";
      step(1'b1, 1'b0, 3'd3); idle(1);
      step(1'b1, 1'b0, 3'd6); idle(1);
      idle(4);
      rd_burst(3'd3); rd_burst(3'd6);
      idle(8);

      // R8: write yields to a read on the same edge
      cur_req = "R8";
      step(1'b0, 1'b0, 3'd4); idle(1);
      idle(2);
      rd_burst(3'd4);
      idle(8);
      step(1'b0, 1'b1, 3'd1); idle(1);
      step(1'b0, 1'b0, 3'd1); idle(1);
      idle(4);
      rd_burst(3'd1);
      idle(8);

      // R2: strobes low only in a complementary-phase cycle
      cur_req = "R2";
      idle(1);
      step(1'b0, 1'b0, 3'd7);
      idle(2);
      rd_burst(3'd7);
      idle(8);

      // R9: address, data and enables wander with no command
      cur_req = "R9";
      be_mode = 1'b1;
      for (int a = 0; a < (1<<AW); a++) step(1'b1, 1'b1, AW'(a));
      be_mode = 1'b0;
      for (int a = 0; a < (1<<AW); a++) rd_burst(AW'(a));
      idle(8);

      // R10: read and write to the same burst overlapping in time
      cur_req = "R10";
      step(1'b0, 1'b1, 3'd5); idle(1);
      step(1'b1, 1'b0, 3'd5); idle(1);
      idle(2);
      step(1'b1, 1'b0, 3'd2); idle(1);
      step(1'b0, 1'b1, 3'd2); idle(1);
      idle(8);
      rd_burst(3'd5); rd_burst(3'd2);
      idle(8);

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule